// File: doc/BRIEF.md
# Line-Scan Sensor Chain Sequencer

This block runs a chain of cascaded line-scan image sensors from the host side. It derives a sensor clock from the system clock. The half period of that clock comes from a divider input. One line is started by a request. For each line the block raises a single global start pulse that spans exactly one falling sensor-clock edge. It then counts the shared preamble of inactive clocks, and after that the active pixels of every sensor in the chain, one sensor straight after the other.

A downstream sampler watches a one-cycle pixel-valid strobe, together with the sensor index and pixel index that go with it, and captures the analog video level at that instant. The sampling point is a programmable number of system cycles after each rising sensor-clock edge. A line-done pulse closes each line. The sequencer then stays idle, with the sensor clock low, until the next request.

Top module: `line_scan_sequencer`

## Requirements
- R1: The sensor clock `sclk` is low in reset and while idle. During a line each high and each low phase lasts H system cycles. H is `half_div` clamped to the range [MIN_HALF, MAX_HALF]. MIN_HALF = max(2, ceil(165 ns / SYS_NS)) and MAX_HALF = floor(1000 ns / SYS_NS).
- R2: `gstart` rises in the same cycle as the first rising edge of `sclk` in a line, after an initial low phase of H cycles. It falls in the cycle of the next rising edge. It is therefore high for 2·H cycles and spans exactly one falling edge, with H cycles before that edge and H cycles after it.
- R3: Number the rising edges after the `gstart` edge from 1. Edges 1 to PREAMBLE (75 by default) are preamble edges and produce no `pix_valid`.
- R4: On every rising edge numbered above PREAMBLE, `pix_valid` is high for exactly one cycle, O cycles after the cycle in which `sclk` rises (the rise cycle counts as 0). O is `sample_ofs` clamped to at most H−1. At no other time is `pix_valid` high.
- R5: The active edge with 0-based number j = edge − PREAMBLE − 1 shows `sensor_idx` = j / PIXELS and `pixel_idx` = j mod PIXELS while `pix_valid` is high. Sensors follow one another with no gap, so each line has NUM_SENSORS·PIXELS strobes.
- R6: `line_done` is high for one cycle, H cycles after `sclk` falls following the last active edge. `sclk` is low at that point, and the block has returned to idle.
- R7: A `start_req` that arrives while a line is in progress is ignored. After `line_done`, no `sclk` edge, `gstart` or `pix_valid` appears until the next `start_req`.
- R8: `half_div` and `sample_ofs` are sampled only when a line starts. Changing them during a line does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to scan one line (acted on when idle) |
| half_div | input | DIV_W | Requested sensor-clock half period in system cycles |
| sample_ofs | input | DIV_W | Sampling offset after each rising sensor-clock edge |
| sclk | output | 1 | Sensor clock |
| gstart | output | 1 | Global start pulse to the sensor chain |
| pix_valid | output | 1 | One-cycle sampling strobe for an active pixel |
| sensor_idx | output | SENS_W | Index of the sensor that owns the current pixel |
| pixel_idx | output | PIX_W | Pixel index within that sensor |
| line_done | output | 1 | One-cycle pulse at the end of a line |

## Verification
The bench builds the block with three sensors of five pixels each and the full 75-clock preamble. It uses a 100 ns system clock, which gives a clamp range of 2 to 10 cycles. With these values, every divider setting from below the lower clamp to above the upper clamp fits in one run, each combined with offsets of zero, one, the last legal value and an oversized value. Short sensors bring every sensor-to-sensor boundary and the end of the line within a few hundred sensor clocks. Separate lines hold the start request through the scan and change the configuration in the middle of a line.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARM  = 2'd1,
        SEQ_SCAN = 2'd2
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lss_cfg_clamp.sv
module lss_cfg_clamp #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 17,
    parameter int MAX_HALF = 100
) (
    input  logic [DIV_W-1:0] half_req,
    input  logic [DIV_W-1:0] ofs_req,
    output logic [DIV_W-1:0] half_c,
    output logic [DIV_W-1:0] ofs_c
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_HALF);

    always_comb begin
        if (half_req < LO) begin
            half_c = LO;
        end else if (half_req > HI) begin
            half_c = HI;
        end else begin
            half_c = half_req;
        end
        ofs_c = (ofs_req >= half_c) ? (half_c - 1'b1) : ofs_req;
    end
endmodule

// File: rtl/lss_half_timer.sv
module lss_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic [DIV_W-1:0] count,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        phase_end = run && (cnt_q == half - 1'b1);
        if (!run || phase_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/lss_index_track.sv
module lss_index_track #(
    parameter int NUM_SENSORS = 8,
    parameter int PIXELS      = 1376,
    parameter int SENS_W      = 3,
    parameter int PIX_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [SENS_W-1:0] sensor,
    output logic [PIX_W-1:0]  pixel
);
    typedef struct packed {
        logic [SENS_W-1:0] sens;
        logic [PIX_W-1:0]  pix;
    } idx_t;

    idx_t idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear) begin
            idx_d = '0;
        end else if (advance) begin
            if (idx_q.pix == PIX_W'(PIXELS - 1)) begin
                idx_d.pix  = '0;
                idx_d.sens = idx_q.sens + 1'b1;
            end else begin
                idx_d.pix = idx_q.pix + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign sensor = idx_q.sens;
    assign pixel  = idx_q.pix;
endmodule

// File: rtl/line_scan_sequencer.sv
module line_scan_sequencer
    import lss_pkg::*;
#(
    parameter int NUM_SENSORS = 8,
    parameter int PIXELS      = 1376,
    parameter int PREAMBLE    = 75,
    parameter int SYS_NS      = 10,
    parameter int DIV_W       = 8,
    localparam int SENS_W     = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1,
    localparam int PIX_W      = (PIXELS > 1) ? $clog2(PIXELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [DIV_W-1:0]  sample_ofs,
    output logic              sclk,
    output logic              gstart,
    output logic              pix_valid,
    output logic [SENS_W-1:0] sensor_idx,
    output logic [PIX_W-1:0]  pixel_idx,
    output logic              line_done
);
    localparam int MIN_HALF = max_int(2, ceil_div(165, SYS_NS));
    localparam int MAX_HALF = max_int(MIN_HALF, 1000 / SYS_NS);
    localparam int TOTAL    = PREAMBLE + NUM_SENSORS * PIXELS;
    localparam int EDGE_W   = $clog2(TOTAL + 1);
    localparam logic [EDGE_W-1:0] LAST_EDGE  = EDGE_W'(TOTAL);
    localparam logic [EDGE_W-1:0] FIRST_PIX  = EDGE_W'(PREAMBLE + 1);

    typedef struct packed {
        seq_state_e        st;
        logic              sclk;
        logic              gstart;
        logic              done;
        logic [EDGE_W-1:0] edge_n;
        logic [DIV_W-1:0]  half;
        logic [DIV_W-1:0]  ofs;
    } seq_t;

    seq_t s_d, s_q;

    logic [DIV_W-1:0] half_c, ofs_c;
    logic [DIV_W-1:0] hcount;
    logic             phase_end;
    logic             idx_clear, idx_adv;

    lss_cfg_clamp #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF),
        .MAX_HALF (MAX_HALF)
    ) u_clamp (
        .half_req (half_div),
        .ofs_req  (sample_ofs),
        .half_c   (half_c),
        .ofs_c    (ofs_c)
    );

    lss_half_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (s_q.st != SEQ_IDLE),
        .half      (s_q.half),
        .count     (hcount),
        .phase_end (phase_end)
    );

    lss_index_track #(
        .NUM_SENSORS (NUM_SENSORS),
        .PIXELS      (PIXELS),
        .SENS_W      (SENS_W),
        .PIX_W       (PIX_W)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idx_clear),
        .advance (idx_adv),
        .sensor  (sensor_idx),
        .pixel   (pixel_idx)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        idx_clear = 1'b0;
        idx_adv   = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start_req) begin
                    s_d.st     = SEQ_ARM;
                    s_d.half   = half_c;
                    s_d.ofs    = ofs_c;
                    s_d.sclk   = 1'b0;
                    s_d.gstart = 1'b0;
                    s_d.edge_n = '0;
                end
            end
            SEQ_ARM: begin
                idx_clear = 1'b1;
                if (phase_end) begin
                    s_d.st     = SEQ_SCAN;
                    s_d.sclk   = 1'b1;
                    s_d.gstart = 1'b1;
                end
            end
            SEQ_SCAN: begin
                if (phase_end) begin
                    if (s_q.sclk) begin
                        s_d.sclk = 1'b0;
                    end else if (s_q.edge_n == LAST_EDGE) begin
                        s_d.st   = SEQ_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.sclk   = 1'b1;
                        s_d.gstart = 1'b0;
                        s_d.edge_n = s_q.edge_n + 1'b1;
                        idx_adv    = (s_q.edge_n >= FIRST_PIX);
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, sclk: 1'b0, gstart: 1'b0, done: 1'b0,
                     edge_n: '0, half: DIV_W'(MIN_HALF), ofs: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk      = s_q.sclk;
    assign gstart    = s_q.gstart;
    assign line_done = s_q.done;
    assign pix_valid = (s_q.st == SEQ_SCAN) && s_q.sclk
                       && (s_q.edge_n >= FIRST_PIX) && (hcount == s_q.ofs);
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
    parameter int NUM_SENSORS = 8,
    parameter int PIXELS      = 1376,
    parameter int SENS_W      = 3,
    parameter int PIX_W       = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              gstart,
    input logic              pix_valid,
    input logic [SENS_W-1:0] sensor_idx,
    input logic [PIX_W-1:0]  pixel_idx,
    input logic              line_done
);
    // R2: start pulse edges line up with rising sensor-clock edges
    a_r2_gstart_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstart) |-> $rose(sclk));
    a_r2_gstart_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gstart) |-> $rose(sclk));
    // R1: each sensor-clock phase lasts at least two system cycles
    a_r1_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);
    a_r1_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);
    // R4: strobe only in the high phase, and never while the start pulse is high
    a_r4_valid_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (sclk && !gstart));
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);
    // R5: indices stay in range while strobing
    a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ((int'(sensor_idx) < NUM_SENSORS) && (int'(pixel_idx) < PIXELS)));
    // R6: the line ends with the block quiet
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (!sclk && !gstart && !pix_valid));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);
endmodule

bind line_scan_sequencer lss_checker #(
    .NUM_SENSORS (NUM_SENSORS),
    .PIXELS      (PIXELS),
    .SENS_W      (SENS_W),
    .PIX_W       (PIX_W)
) u_lss_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .gstart     (gstart),
    .pix_valid  (pix_valid),
    .sensor_idx (sensor_idx),
    .pixel_idx  (pixel_idx),
    .line_done  (line_done)
);

// File: tb/sim_line_scan_sequencer.sv
`timescale 1ns/1ps
module sim_line_scan_sequencer;
    localparam int CLK_PERIOD = 100;
    localparam int NS   = 3;
    localparam int PIX  = 5;
    localparam int PRE  = 75;
    localparam int DW   = 5;
    localparam int MINH = ((165 + CLK_PERIOD - 1) / CLK_PERIOD < 2) ? 2 : (165 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int MAXH = 1000 / CLK_PERIOD;
    localparam int SW   = (NS > 1) ? $clog2(NS) : 1;
    localparam int PW   = (PIX > 1) ? $clog2(PIX) : 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic [DW-1:0] half_div = '0;
    logic [DW-1:0] sample_ofs = '0;
    logic          sclk, gstart, pix_valid, line_done;
    logic [SW-1:0] sensor_idx;
    logic [PW-1:0] pixel_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_scan_sequencer #(
        .NUM_SENSORS (NS),
        .PIXELS      (PIX),
        .PREAMBLE    (PRE),
        .SYS_NS      (CLK_PERIOD),
        .DIV_W       (DW)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .half_div   (half_div),
        .sample_ofs (sample_ofs),
        .sclk       (sclk),
        .gstart     (gstart),
        .pix_valid  (pix_valid),
        .sensor_idx (sensor_idx),
        .pixel_idx  (pixel_idx),
        .line_done  (line_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_line(input int hd, input int od, input bit hold_req, input bit cfg_change);
        int eh, eo, prev, seg, rc, since_rise, since_fall, gs_falls, gs_len;
        int pre_valid, vcnt, cyc, n, j;
        bit done, expv;
        eh = (hd < MINH) ? MINH : ((hd > MAXH) ? MAXH : hd);
        eo = (od > eh - 1) ? eh - 1 : od;
        @(negedge clk);
        half_div = DW'(hd);
        sample_ofs = DW'(od);
        start_req = 1'b1;
        @(negedge clk);
        if (!hold_req) start_req = 1'b0;
        prev = 0; seg = 0; rc = 0; since_rise = 0; since_fall = 0;
        gs_falls = 0; gs_len = 0; pre_valid = 0; vcnt = 0; cyc = 0; done = 0;
        while (!done && cyc < 20000) begin
            if (int'(sclk) != prev) begin
                if (rc > 0) chk(seg == eh, "R1 phase length", seg, eh);
                seg = 1;
            end else begin
                seg++;
            end
            if (sclk && prev == 0) begin
                rc++;
                since_rise = 0;
                if (rc == 1) chk(gstart == 1'b1, "R2 gstart with first rise", gstart, 1);
                if (rc == 2) chk(gstart == 1'b0, "R2 gstart drop on next rise", gstart, 0);
            end else begin
                since_rise++;
            end
            if (!sclk && prev == 1) begin
                since_fall = 0;
                if (gstart) gs_falls++;
            end else begin
                since_fall++;
            end
            if (gstart) gs_len++;
            n = rc - 1;
            if (pix_valid && n <= PRE) pre_valid++;
            expv = sclk && (rc >= 1) && (n > PRE) && (since_rise == eo);
            if (pix_valid || expv)
                chk(pix_valid == expv, "R4 strobe timing", pix_valid, expv);
            if (pix_valid && expv) begin
                j = n - PRE - 1;
                chk(int'(sensor_idx) == j / PIX, "R5 sensor index", sensor_idx, j / PIX);
                chk(int'(pixel_idx) == j % PIX, "R5 pixel index", pixel_idx, j % PIX);
                vcnt++;
            end
            if (cfg_change && rc == 10) begin
                half_div = DW'(hd ^ 5);   // R8: mid-line change must not matter
                sample_ofs = DW'(od ^ 3);
            end
            if (hold_req && rc == 40) start_req = 1'b0;
            if (line_done) begin
                done = 1;
                chk(n == PRE + NS * PIX, "R6 edges before done", n, PRE + NS * PIX);
                chk(since_fall == eh, "R6 done delay after fall", since_fall, eh);
                chk(sclk == 1'b0, "R6 sclk low at done", sclk, 0);
            end
            prev = int'(sclk);
            cyc++;
            @(negedge clk);
        end
        chk(done, "R6 line finished", done, 1);
        chk(gs_falls == 1, "R2 falls under gstart", gs_falls, 1);
        chk(gs_len == 2 * eh, "R2 gstart width", gs_len, 2 * eh);
        chk(pre_valid == 0, "R3 preamble strobes", pre_valid, 0);
        chk(vcnt == NS * PIX, "R5 strobe count", vcnt, NS * PIX);
        half_div = DW'(hd);
        sample_ofs = DW'(od);
        begin
            int act;
            act = 0;
            repeat (3 * MAXH) begin
                @(negedge clk);
                if (sclk || gstart || pix_valid || line_done) act++;
            end
            chk(act == 0, "R7 idle without request", act, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1 sclk low in reset", sclk, 0);
        chk(gstart == 1'b0 && pix_valid == 1'b0 && line_done == 1'b0,
            "R6 outputs quiet in reset", gstart | pix_valid | line_done, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sclk == 1'b0, "R7 idle after reset", sclk, 0);
        for (int hd = 0; hd <= 12; hd++) begin
            for (int oi = 0; oi < 4; oi++) begin
                int eh, od;
                eh = (hd < MINH) ? MINH : ((hd > MAXH) ? MAXH : hd);
                od = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? eh - 1 : 31;
                run_line(hd, od, 1'b0, 1'b0);
            end
        end
        run_line(4, 2, 1'b1, 1'b0);   // R7: held request ignored during the line
        run_line(6, 3, 1'b0, 1'b1);   // R8: configuration change mid-line
        run_line(1, 9, 1'b1, 1'b1);   // R7 and R8 together at the clamp edge
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule